// File: doc/BRIEF.md
# Iterative GF(2) Linear System Solver

This block solves a square system of binary linear equations A·x = b, where every coefficient, right-hand-side bit and unknown is a single bit. Multiplication is AND and addition is XOR. It does not invert the matrix and does not run an elimination. It starts from the guess x = b and, on every busy clock cycle, recomputes all unknowns at once from the previous guess. Each update uses x_i = b_i XOR (XOR over j≠i of a_ij AND x_j). This relies on every diagonal coefficient being 1.

When an update leaves the guess unchanged, the guess is a fixed point of the equations. One further cycle then re-evaluates A·x against b and reports the outcome. Over GF(2) the feedback can also cycle forever. An update counter therefore stops the run after a parameterised number of updates, and such a run is always reported as not valid.

Software or a neighbouring engine loads the matrix one row per write and the right-hand side as a single vector while the block is idle. It then pulses start and waits for the one-cycle done pulse. The number of unknowns is a parameter; the default build has four, and 64 is the intended upper size.

Top module: `gf2_feedback_solver`

## Requirements
- R1: While busy is low, a cycle with rowWe high stores rowData into matrix row rowIdx, where bit j of the row is the coefficient of unknown j. A cycle with rhsWe high stores rhsData as b, where bit i is the right-hand side of row i.
- R2: A start pulse seen while idle raises busy on the next cycle. On that same cycle xOut shows the stored b as the first estimate.
- R3: Each busy iteration cycle replaces all estimate bits in parallel with b_i XOR (XOR over j≠i of a_ij AND x_j), using the previous estimate. The stored diagonal bits are never read; they are taken to be 1 both here and in the final residual check.
- R4: Iteration stops at the first update that would leave the estimate unchanged. With the identity matrix, done is high exactly two cycles after busy is first seen high.
- R5: After LIMIT updates (default 4·N) without settling, iteration stops. done then rises one cycle later with valid low. For N=4 this is 17 cycles after busy is first seen high.
- R6: done is a single-cycle pulse that rises on the same edge where busy falls. valid can be high only during that pulse, and only if every row of A·x equals b.
- R7: While busy is high, start, rowWe and rhsWe have no effect. A repeated solve of the same system therefore behaves exactly as the first one did.
- R8: xOut always shows the current estimate and keeps the final result after done until the next start.
- R9: A synchronous active-high reset clears busy, done, valid, the update counter and the estimate, so xOut reads 0.
- R10: When a run ends with valid high, xOut equals the unique solution of the invertible system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rowWe | input | 1 | Write strobe for one matrix row |
| rowIdx | input | $clog2(N) | Row selected by rowWe |
| rowData | input | N | Row coefficients, bit j multiplies unknown j |
| rhsWe | input | 1 | Write strobe for the right-hand side |
| rhsData | input | N | Right-hand side vector, bit i for row i |
| start | input | 1 | Begin a solve (ignored while busy) |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle end-of-solve pulse |
| valid | output | 1 | High with done when A·x equals b |
| xOut | output | N | Current estimate / final solution |

## Verification
On every cycle, the assertions check the following:
- done is a single-cycle pulse, and valid never appears without it.
- A run that hits the limit never reports valid.
- The update counter stays within its bound.
- A settled estimate always satisfies every equation.
- The stored system stays frozen while busy, and reset clears the control outputs.

Some behaviour can only be shown by the bench scenarios, driven by a cycle-level reference model and an independent elimination solver:
- The result equals the true solution of a random invertible system.
- The identity matrix and an oscillating system finish in the right number of cycles.
- Diagonal bits are ignored.
- Disturbing inputs during a run leave a repeated solve unchanged.

// File: rtl/gf2s_pkg.sv
package gf2s_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic seed;  // copy b into the estimate
    logic step;  // take one parallel update
    logic lock;  // freeze the stored system
  } dpCtrl_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ITER  = 2'd1,
    S_CHECK = 2'd2
  } solveState_t;

endpackage

// File: rtl/gf2s_datapath.sv
module gf2s_datapath
  import gf2s_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  dpCtrl_t       ctrl,
  input  logic          rowWe,
  input  logic [IW-1:0] rowIdx,
  input  logic [N-1:0]  rowData,
  input  logic          rhsWe,
  input  logic [N-1:0]  rhsData,
  output logic [N-1:0]  xEst,
  output logic          changes,
  output logic          resOk
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] aRows [N];
  logic [N-1:0] bVec;
  logic [N-1:0] xReg;
  logic [N-1:0] nextEst;
  logic [N-1:0] rowMatch;
  logic [N*N-1:0] aFlat;

  // System storage: writable only while the sequencer is idle
  always_ff @(posedge clk) begin
    if (!ctrl.lock) begin
      if (rowWe && (int'(rowIdx) < N)) aRows[rowIdx] <= rowData;
      if (rhsWe) bVec <= rhsData;
    end
  end

  // Estimate register
  always_ff @(posedge clk) begin
    if (rst) xReg <= '0;
    else if (ctrl.seed) xReg <= bVec;
    else if (ctrl.step) xReg <= nextEst;
  end

  // One equation per row; the diagonal is masked and taken as 1
  for (genvar gi = 0; gi < N; gi++) begin : g_row
    logic [N-1:0] offDiag;
    logic         feedSum;
    assign offDiag       = aRows[gi] & ~(ONE << gi);
    assign feedSum       = ^(offDiag & xReg);
    assign nextEst[gi]   = bVec[gi] ^ feedSum;
    assign rowMatch[gi]  = ~(feedSum ^ xReg[gi] ^ bVec[gi]);
    assign aFlat[gi*N +: N] = aRows[gi];
  end

  assign changes = (nextEst != xReg);
  assign resOk   = &rowMatch;
  assign xEst    = xReg;

  // R7: stored system does not move during a solve
  assert_frozen_matrix_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.lock |=> $stable(aFlat));
  assert_frozen_rhs_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.lock |=> $stable(bVec));
  // R8: estimate only moves on seed or step
  assert_hold_estimate_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.seed && !ctrl.step) |=> $stable(xReg));

endmodule

// File: rtl/gf2s_control.sv
module gf2s_control
  import gf2s_pkg::*;
#(
  parameter int LIMIT = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    changes,
  input  logic    resOk,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done,
  output logic    valid
);

  localparam int CW = $clog2(LIMIT + 1);

  solveState_t    state;
  logic [CW-1:0]  updCnt;
  logic           hitLim;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      updCnt <= '0;
      hitLim <= 1'b0;
      done   <= 1'b0;
      valid  <= 1'b0;
    end else begin
      done  <= 1'b0;
      valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_ITER;
            updCnt <= '0;
            hitLim <= 1'b0;
          end
        end
        S_ITER: begin
          if (!changes) begin
            state <= S_CHECK;
          end else begin
            updCnt <= updCnt + 1'b1;
            if (updCnt == CW'(LIMIT - 1)) begin
              hitLim <= 1'b1;
              state  <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          done  <= 1'b1;
          valid <= resOk & ~hitLim;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.seed = (state == S_IDLE) && start;
    ctrl.step = (state == S_ITER) && changes;
    ctrl.lock = (state != S_IDLE);
    busy      = (state != S_IDLE);
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_valid_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> done);
  assert_limit_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK && hitLim) |=> !valid);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    updCnt <= CW'(LIMIT));
  assert_fixed_point_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK && !hitLim) |-> resOk);
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_ITER && start && changes && updCnt != CW'(LIMIT - 1)) |=> busy);
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!busy && !done && !valid));

endmodule

// File: rtl/gf2_feedback_solver.sv
module gf2_feedback_solver
  import gf2s_pkg::*;
#(
  parameter int N     = 4,
  parameter int LIMIT = 4 * N
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rowWe,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0] rowIdx,
  input  logic [N-1:0]                      rowData,
  input  logic                              rhsWe,
  input  logic [N-1:0]                      rhsData,
  input  logic                              start,
  output logic                              busy,
  output logic                              done,
  output logic                              valid,
  output logic [N-1:0]                      xOut
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  dpCtrl_t ctrl;
  logic    changes;
  logic    resOk;

  gf2s_control #(.LIMIT(LIMIT)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .changes(changes), .resOk(resOk),
    .ctrl(ctrl), .busy(busy), .done(done), .valid(valid)
  );

  gf2s_datapath #(.N(N), .IW(IW)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .rowWe(rowWe), .rowIdx(rowIdx), .rowData(rowData),
    .rhsWe(rhsWe), .rhsData(rhsData),
    .xEst(xOut), .changes(changes), .resOk(resOk)
  );

endmodule

// File: tb/tb_gf2_feedback_solver.sv
`timescale 1ns/1ps
module tb_gf2_feedback_solver;

  localparam int N   = 4;
  localparam int LIM = 4 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rowWe = 1'b0;
  logic [1:0]   rowIdx = '0;
  logic [N-1:0] rowData = '0;
  logic         rhsWe = 1'b0;
  logic [N-1:0] rhsData = '0;
  logic         start = 1'b0;
  logic         busy, done, valid;
  logic [N-1:0] xOut;

  gf2_feedback_solver #(.N(N)) dut (
    .clk(clk), .rst(rst), .rowWe(rowWe), .rowIdx(rowIdx), .rowData(rowData),
    .rhsWe(rhsWe), .rhsData(rhsData), .start(start),
    .busy(busy), .done(done), .valid(valid), .xOut(xOut)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit cmpOn   = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] mA [N];
  logic [N-1:0] mB = '0;
  logic [N-1:0] mX = '0;
  int mState = 0;
  int mCnt = 0;
  bit mHit = 0, mDone = 0, mValid = 0;

  function automatic logic [N-1:0] modelNext();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[i] = mB[i];
      for (int j = 0; j < N; j++) if (j != i) r[i] ^= mA[i][j] & mX[j];
    end
    return r;
  endfunction

  function automatic bit modelOk();
    bit s;
    for (int i = 0; i < N; i++) begin
      s = mX[i] ^ mB[i];
      for (int j = 0; j < N; j++) if (j != i) s ^= mA[i][j] & mX[j];
      if (s) return 1'b0;
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] nx;
    bit ok, wasIdle;
    if (rst) begin
      mState = 0; mCnt = 0; mHit = 0; mDone = 0; mValid = 0; mX = '0;
    end else begin
      nx = modelNext();
      ok = modelOk();
      wasIdle = (mState == 0);
      mDone = 0; mValid = 0;
      case (mState)
        0: if (start) begin mX = mB; mCnt = 0; mHit = 0; mState = 1; end
        1: if (nx == mX) mState = 2;
           else begin
             mX = nx; mCnt++;
             if (mCnt == LIM) begin mHit = 1; mState = 2; end
           end
        default: begin mDone = 1; mValid = ok && !mHit; mState = 0; end
      endcase
      if (wasIdle) begin
        if (rowWe) mA[rowIdx] = rowData;
        if (rhsWe) mB = rhsData;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      chk(busy == (mState != 0), "R2 busy", 64'(busy), 64'(mState != 0));
      chk(done == mDone, "R6 done", 64'(done), 64'(mDone));
      chk(valid == mValid, "R6 valid", 64'(valid), 64'(mValid));
      chk(xOut == mX, "R3 xOut", 64'(xOut), 64'(mX));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- elimination reference ----------------
  function automatic bit solveRef(input logic [N-1:0] m [N], input logic [N-1:0] bb,
                                  output logic [N-1:0] xs);
    logic [N:0] aug [N];
    logic [N:0] t;
    int p;
    for (int i = 0; i < N; i++) aug[i] = {bb[i], m[i]};
    for (int c = 0; c < N; c++) begin
      p = -1;
      for (int r = c; r < N; r++) if (p < 0 && aug[r][c]) p = r;
      if (p < 0) begin xs = '0; return 1'b0; end
      t = aug[c]; aug[c] = aug[p]; aug[p] = t;
      for (int r = 0; r < N; r++) if (r != c && aug[r][c]) aug[r] ^= aug[c];
    end
    for (int i = 0; i < N; i++) xs[i] = aug[i][N];
    return 1'b1;
  endfunction

  // ---------------- stimulus tasks ----------------
  task automatic loadSys(input logic [N-1:0] m [N], input logic [N-1:0] bb);
    for (int i = 0; i < N; i++) begin
      rowWe = 1'b1; rowIdx = 2'(i); rowData = m[i];
      @(negedge clk);
    end
    rowWe = 1'b0;
    rhsWe = 1'b1; rhsData = bb;
    @(negedge clk);
    rhsWe = 1'b0;
  endtask

  task automatic runSolve(input bit disturb, output int cyc, output bit v,
                          output logic [N-1:0] xr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    cyc = 0;
    while (!done && cyc < 200) begin
      if (disturb && cyc == 3) begin
        start = 1'b1; rowWe = 1'b1; rowIdx = '0; rowData = '0;
        rhsWe = 1'b1; rhsData = '1;
      end
      @(negedge clk);
      start = 1'b0; rowWe = 1'b0; rhsWe = 1'b0;
      cyc++;
    end
    v  = valid;
    xr = xOut;
    chk(busy == 1'b0, "R6 busy falls with done", 64'(busy), 64'd0);
  endtask

  initial begin
    logic [N-1:0] m [N];
    logic [N-1:0] bb, xr, xref, xHeld;
    int cyc, cyc2;
    bit v, v2, inv;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmpOn = 1'b1;
    chk(busy == 0 && done == 0 && valid == 0, "R9 reset outputs",
        64'({busy, done, valid}), 64'd0);
    chk(xOut == '0, "R9 reset estimate", 64'(xOut), 64'd0);

    // Identity: settles at once (R4), R1 load path
    for (int i = 0; i < N; i++) m[i] = N'(1) << i;
    bb = 4'b1011;
    loadSys(m, bb);
    runSolve(1'b0, cyc, v, xr);
    chk(cyc == 2, "R4 identity latency", 64'(cyc), 64'd2);
    chk(v == 1'b1, "R4 identity valid", 64'(v), 64'd1);
    chk(xr == bb, "R1 identity result", 64'(xr), 64'(bb));
    xHeld = xOut;
    repeat (4) @(negedge clk);
    chk(xOut == xHeld, "R8 result held", 64'(xOut), 64'(xHeld));

    // Upper triangular: guaranteed convergence (R4, R10)
    m[0] = 4'b1011; m[1] = 4'b1110; m[2] = 4'b1100; m[3] = 4'b1000;
    bb = 4'b0110;
    loadSys(m, bb);
    inv = solveRef(m, bb, xref);
    runSolve(1'b0, cyc, v, xr);
    chk(v == 1'b1, "R4 triangular converges", 64'(v), 64'd1);
    chk(xr == xref, "R10 triangular solution", 64'(xr), 64'(xref));

    // Same off-diagonal with diagonal bits cleared: same answer (R3)
    for (int i = 0; i < N; i++) m[i][i] = 1'b0;
    loadSys(m, bb);
    runSolve(1'b0, cyc, v, xr);
    chk(v == 1'b1 && xr == xref, "R3 diagonal ignored", 64'(xr), 64'(xref));

    // Oscillating system: off-diagonal part has no fixed nilpotency (R5)
    m[0] = 4'b0011; m[1] = 4'b0110; m[2] = 4'b0111; m[3] = 4'b1000;
    bb = 4'b0001;
    loadSys(m, bb);
    runSolve(1'b0, cyc, v, xr);
    chk(cyc == LIM + 1, "R5 limit latency", 64'(cyc), 64'(LIM + 1));
    chk(v == 1'b0, "R5 limit invalid", 64'(v), 64'd0);

    // Same run with start/row/rhs writes during busy: no effect (R7)
    runSolve(1'b1, cyc2, v2, xr);
    runSolve(1'b0, cyc, v, xr);
    chk(cyc2 == LIM + 1 && v2 == 1'b0, "R7 disturbed run", 64'(cyc2), 64'(LIM + 1));
    chk(cyc == LIM + 1 && v == 1'b0, "R7 system kept", 64'(cyc), 64'(LIM + 1));

    // Random unit-diagonal invertible systems (R10, R5)
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < N; i++) begin
        m[i] = N'($urandom);
        m[i][i] = 1'b1;
      end
      bb = N'($urandom);
      inv = solveRef(m, bb, xref);
      if (inv) begin
        loadSys(m, bb);
        runSolve(1'b0, cyc, v, xr);
        if (v) chk(xr == xref, "R10 random solution", 64'(xr), 64'(xref));
        else   chk(cyc == LIM + 1, "R5 random limit", 64'(cyc), 64'(LIM + 1));
      end
    end

    // Reset during a solve (R9)
    m[0] = 4'b0011; m[1] = 4'b0110; m[2] = 4'b0111; m[3] = 4'b1000;
    bb = 4'b0001;
    loadSys(m, bb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && done == 0 && valid == 0, "R9 reset mid-solve",
        64'({busy, done, valid}), 64'd0);
    chk(xOut == '0, "R9 estimate cleared", 64'(xOut), 64'd0);
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule